// File: doc/BRIEF.md
# Ethernet PHY Management Register Model

This block stands in for the management register file of a 10/100 Ethernet transceiver. A management controller presents one 5-bit register number per cycle together with an optional write strobe and a 16-bit write word. Writes land in a 32-entry storage array on the clock edge. The read word is a combinational function of the register number, so it answers in the same cycle.

Most registers behave as plain storage. Three of them are computed at read time from the stored advertisement register and a link input. The status register, the link-partner register and the diagnostic register therefore always describe a finished auto-negotiation that agrees with whatever abilities the local side advertised. When the link input is low, the status and diagnostic registers read as zero.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After reset, plain registers read as follows: register 0 = 0x3100, register 2 = 0x0300, register 3 = 0xE400, register 4 (advertisement) = 0x01E1, and every other plain register = 0x0000.
- R2: With link_up high, a read of register 1 returns 0x782C. That value has bits 14, 13, 12 and 11 (abilities), bit 5 (negotiation complete), bit 3 (negotiation able) and bit 2 (link) set.
- R3: With link_up low, a read of register 1 returns 0x0000.
- R4: A read of register 5 returns 0x4000 | (register4 & 0x01E0) | 0x0001, whatever the state of link_up.
- R5: With link_up high, a read of register 18 returns bit 10 = register4[7] | register4[8] and bit 11 = register4[8] | register4[6], with all other bits 0.
- R6: With link_up low, a read of register 18 returns 0x0000.
- R7: When wr_en is high at a rising clock edge, req_reg's register takes wr_data. A later read of a plain register returns that value.
- R8: A write to register 1, 5 or 18 is stored, but reads of those registers keep returning the computed value.
- R9: A change on link_up shows in the computed read values in the same cycle, with no clock edge needed.
- R10: With wr_en low, wr_data presented across a clock edge changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_up | input | 1 | Link state reflected by the computed registers |
| req_reg | input | 5 | Register number for the read and the write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write word |
| rd_data | output | 16 | Read word for req_reg (combinational) |

## Verification
The bench builds the block with its default 5-bit register number, which gives all 32 registers. Every register can then be reached by both directed and random requests, including the three computed ones at numbers 1, 5 and 18. Random advertisement words cover all sixteen combinations of the four ability bits. Link toggles are mixed in between reads, so the computed values are seen in both link states after arbitrary write histories.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int WORD_W = 16;
  typedef logic [WORD_W-1:0] word_t;

  localparam int STATUS_IDX  = 1;
  localparam int ADV_IDX     = 4;
  localparam int PARTNER_IDX = 5;
  localparam int DIAG_IDX    = 18;

  // Power-on contents of the storage array
  function automatic word_t reset_word(input int idx);
    case (idx)
      0:       return 16'h3100;
      2:       return 16'h0300;
      3:       return 16'hE400;
      4:       return 16'h01E1;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/phy_reg_store.sv
module phy_reg_store
  import phy_mgmt_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  word_t             wr_data,
  output word_t             rd_word,
  output word_t             adv_word
);
  localparam int NUM_REGS = 1 << ADDR_W;

  word_t mem [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= reset_word(i);
    end else if (wr_en) begin
      mem[addr] <= wr_data;
    end
  end

  assign rd_word  = mem[addr];
  assign adv_word = mem[ADV_IDX];

  // R7: a strobed write is held in the array after the edge
  p_write_lands_r7: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> mem[$past(addr)] == $past(wr_data));

  // R10: without the strobe the addressed entry is unchanged
  p_no_strobe_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> mem[$past(addr)] == $past(rd_word));
endmodule

// File: rtl/phy_status_synth.sv
module phy_status_synth
  import phy_mgmt_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  link_up,
  input  word_t adv_word,
  output word_t status_word,
  output word_t partner_word,
  output word_t diag_word
);
  localparam word_t STATUS_UP   = 16'h782C;
  localparam word_t ABILITY_MSK = 16'h01E0;

  logic fast_mode;
  logic full_dup;

  assign fast_mode = adv_word[7] | adv_word[8];
  assign full_dup  = adv_word[8] | adv_word[6];

  always_comb begin
    status_word  = link_up ? STATUS_UP : '0;
    partner_word = 16'h4001 | (adv_word & ABILITY_MSK);
    diag_word    = '0;
    if (link_up) begin
      diag_word[10] = fast_mode;
      diag_word[11] = full_dup;
    end
  end

  // R2: a live link reports exactly seven status bits
  p_status_bits_r2: assert property (@(posedge clk) disable iff (rst)
    link_up |-> $countones(status_word) == 7);

  // R4: partner word always flags success and negotiation support
  p_partner_flags_r4: assert property (@(posedge clk) disable iff (rst)
    partner_word[14] && partner_word[0]);

  // R6: diagnostics are silent without a link
  p_diag_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !link_up |-> diag_word == '0);
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              link_up,
  input  logic [ADDR_W-1:0] req_reg,
  input  logic              wr_en,
  input  logic [15:0]       wr_data,
  output logic [15:0]       rd_data
);
  word_t stored_word, adv_word;
  word_t status_word, partner_word, diag_word;

  phy_reg_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(req_reg),
    .wr_data(wr_data), .rd_word(stored_word), .adv_word(adv_word)
  );

  phy_status_synth u_synth (
    .clk(clk), .rst(rst), .link_up(link_up), .adv_word(adv_word),
    .status_word(status_word), .partner_word(partner_word),
    .diag_word(diag_word)
  );

  always_comb begin
    case (int'(req_reg))
      STATUS_IDX:  rd_data = status_word;
      PARTNER_IDX: rd_data = partner_word;
      DIAG_IDX:    rd_data = diag_word;
      default:     rd_data = stored_word;
    endcase
  end

  // R3: link down gives a blank status read at the port
  p_status_down_r3: assert property (@(posedge clk) disable iff (rst)
    (!link_up && int'(req_reg) == STATUS_IDX) |-> rd_data == '0);

  // R8: a write to a computed register does not alter what it reads
  p_computed_ignores_write_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && int'(req_reg) == PARTNER_IDX) |-> rd_data[14]);
endmodule

// File: tb/phy_mgmt_regs_test.sv
module phy_mgmt_regs_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst = 1;
  logic        link_up = 1;
  logic [4:0]  req_reg = '0;
  logic        wr_en = 0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_mgmt_regs uut (
    .clk(clk), .rst(rst), .link_up(link_up), .req_reg(req_reg),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
  );

  function automatic logic [15:0] expect_word(input int a, input logic lk);
    logic [15:0] adv, d;
    adv = model[4];
    case (a)
      1:  return lk ? 16'h782C : 16'h0000;
      5:  return 16'h4000 | (adv & 16'h01E0) | 16'h0001;
      18: begin
        d = '0;
        if (lk) begin
          d[10] = adv[7] | adv[8];
          d[11] = adv[8] | adv[6];
        end
        return d;
      end
      default: return model[a];
    endcase
  endfunction

  function automatic string tag_for(input int a);
    case (a)
      1:  return link_up ? "R2" : "R3";
      5:  return "R4";
      18: return link_up ? "R5" : "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s reg=%0d actual=%h expected=%h", tag, req_reg, act, exp);
    end
  endtask

  task automatic do_write(input int a, input logic [15:0] d);
    @(negedge clk);
    req_reg = a[4:0]; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
    model[a] = d;
  endtask

  task automatic do_read(input int a, input string tag);
    @(negedge clk);
    req_reg = a[4:0];
    #1 check(tag, rd_data, expect_word(a, link_up));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int r;
    for (int i = 0; i < 32; i++) model[i] = '0;
    model[0] = 16'h3100; model[2] = 16'h0300;
    model[3] = 16'hE400; model[4] = 16'h01E1;
    r = $urandom(32'd4242);
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1: reset contents of every plain register
    for (int i = 0; i < 32; i++)
      if (i != 1 && i != 5 && i != 18) do_read(i, "R1");
    do_read(1, "R2");
    do_read(5, "R4");
    do_read(18, "R5");

    // R3 R6 R9: link drop seen without any clock edge
    @(negedge clk); req_reg = 5'd1; link_up = 0;
    #1 check("R9", rd_data, 16'h0000);
    do_read(1, "R3");
    do_read(18, "R6");
    do_read(5, "R4");
    link_up = 1;
    #1 check("R9", rd_data, expect_word(5, 1'b1));

    // R5: each single ability bit
    do_write(4, 16'h0020); do_read(18, "R5");
    do_write(4, 16'h0040); do_read(18, "R5"); do_read(5, "R4");
    do_write(4, 16'h0080); do_read(18, "R5");
    do_write(4, 16'h0100); do_read(18, "R5"); do_read(5, "R4");
    do_write(4, 16'hFE1F); do_read(18, "R5"); do_read(5, "R4");

    // R8: writes to computed registers leave reads computed
    do_write(1, 16'h0000);  do_read(1, "R8");
    do_write(5, 16'h0000);  do_read(5, "R8");
    do_write(18, 16'hFFFF); do_read(18, "R8");

    // R10: data without strobe is ignored
    @(negedge clk); req_reg = 5'd9; wr_data = 16'hBEEF; wr_en = 0;
    @(negedge clk); wr_data = 16'h0000;
    do_read(9, "R10");
    do_write(9, 16'h1234); do_read(9, "R7");
    do_write(31, 16'hA5A5); do_read(31, "R7");

    // Random mix of writes, reads and link toggles
    for (int n = 0; n < 400; n++) begin
      int a, op;
      a = int'($urandom_range(0, 31));
      op = int'($urandom_range(0, 9));
      if (op < 4) do_write(a, 16'($urandom));
      else if (op < 5) link_up = ~link_up;
      else if (op < 6) do_write(4, 16'($urandom));
      else do_read(a, tag_for(a));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule